// File: doc/BRIEF.md
# Dual-Loop PLL Powerdown Controller

This block sets the power state of each loop in a multi-loop frequency synthesizer (two loops by default, an intermediate-frequency loop and a radio-frequency loop). For every loop it watches a latch strobe from the serial control interface. On each strobe it takes in that loop's powerdown request bit, which is the value being latched. It also takes in the loop's charge-pump high-impedance bit, a level that was latched earlier from the reference-divider word. It then moves the loop between three states: active, waiting for the charge pump, and powered down.

The high-impedance bit chooses how a powerdown request is handled. When the bit is set, the loop powers down on the clock edge that samples the strobe. When the bit is clear, the request is synchronous: the loop waits until its charge pump reports idle, so that the output frequency does not jump, and only then powers down. A powered-down loop holds its dividers in their load state and debiases its input buffer. The shared reference oscillator is switched off only when every loop is powered down. Strobes are accepted in every state. A strobe that latches a cleared powerdown bit powers the loop up on the next edge, and the same strobe cancels a synchronous request that is still waiting.

Each charge-pump idle input passes through a synchronizer of IDLE_SYNC_STAGES flops before the state machine sees it. When the parameter is 0, the input goes straight to the state machine.

Top module: `pll_pwrdn_ctrl`

## Requirements
- R1: After reset every loop is active: loop_down, div_hold, fin_debias, cp_hiz and osc_off are all 0.
- R2: A strobe with ref_hiz_bit=0 and pd_bit=0 leaves the loop fully active, with loop_down=0 and cp_hiz=0.
- R3: When ref_hiz_bit=1 and the loop is active, cp_hiz=1 while loop_down stays 0. This state follows a strobe with pd_bit=0.
- R4: A strobe with ref_hiz_bit=0 and pd_bit=1 does not lower power immediately. loop_down rises exactly IDLE_SYNC_STAGES+1 clock edges after the first edge that samples cp_idle high, and never sooner than one edge after the strobe edge.
- R5: A strobe with ref_hiz_bit=1 and pd_bit=1 sets loop_down on the edge that samples it, whatever the value of cp_idle.
- R6: div_hold and fin_debias are each equal to loop_down. cp_hiz is 1 whenever loop_down is 1.
- R7: osc_off is 1 exactly when loop_down is 1 for every loop.
- R8: From the powered-down state, in either mode, a strobe with pd_bit=0 clears loop_down on the edge that samples it.
- R9: A pending synchronous request is cancelled by a strobe with pd_bit=0, and cp_idle rising later does not power the loop down.
- R10: Strobes are accepted in every state. A strobe with pd_bit=1 keeps a powered-down loop down. Changes on pd_bit without a strobe have no effect. A strobe for one loop leaves the other loops unchanged.
- R11: While a synchronous request is pending, a strobe with ref_hiz_bit=1 and pd_bit=1 powers the loop down on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| latch_stb | input | NUM_LOOPS | One-cycle strobe per loop: that loop's N word is being latched |
| ref_hiz_bit | input | NUM_LOOPS | Latched charge-pump high-impedance bit per loop (level) |
| pd_bit | input | NUM_LOOPS | Powerdown bit latched when the loop's strobe is high |
| cp_idle | input | NUM_LOOPS | Charge pump of the loop has reached high impedance |
| loop_down | output | NUM_LOOPS | Loop is powered down |
| div_hold | output | NUM_LOOPS | Force the R and N dividers to their load state |
| fin_debias | output | NUM_LOOPS | Debias the loop's input buffer to high impedance |
| cp_hiz | output | NUM_LOOPS | Charge-pump output held in high impedance |
| osc_off | output | 1 | Disable the shared reference oscillator |

## Verification
The bound checker watches several rules on every cycle. It checks the one-edge response to strobes: immediate powerdown (R5, R11), immediate power-up (R8), and no immediate drop on a synchronous request (R4). It also checks that a down loop stays down without a strobe, and that the output group and the oscillator gate stay consistent (R6, R7). The bench's scenarios are needed for the things a one-cycle property cannot see. These are the exact synchronizer latency before a synchronous powerdown takes effect, the cancellation of a waiting request followed by a later idle indication, that pd_bit is ignored without a strobe, and that loops are independent of each other.

// File: rtl/pll_pwrdn_pkg.sv
package pll_pwrdn_pkg;
   typedef enum logic [1:0] {
      PS_ACTIVE = 2'd0,
      PS_WAIT   = 2'd1,
      PS_DOWN   = 2'd2
   } pwr_state_e;

   localparam int unsigned MAX_LOOPS       = 8;
   localparam int unsigned MAX_SYNC_STAGES = 4;
endpackage

// File: rtl/pll_pwrdn_idle_sync.sv
module pll_pwrdn_idle_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_i,
   output logic idle_o
);
   if (STAGES > pll_pwrdn_pkg::MAX_SYNC_STAGES) begin : g_bad_stages
      $error("pll_pwrdn_idle_sync: STAGES above supported maximum");
   end

   if (STAGES == 0) begin : g_direct
      assign idle_o = idle_i;
   end else begin : g_flops
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], idle_i};
      end
      assign idle_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/pll_pwrdn_loop_fsm.sv
module pll_pwrdn_loop_fsm
   import pll_pwrdn_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic hiz_i,
   input  logic pd_i,
   input  logic idle_i,
   output logic down_o,
   output logic hold_o,
   output logic debias_o,
   output logic cp_hiz_o
);
   pwr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_ACTIVE: begin
            if (stb_i && pd_i) state_d = hiz_i ? PS_DOWN : PS_WAIT;
         end
         PS_WAIT: begin
            if (stb_i && !pd_i)     state_d = PS_ACTIVE;
            else if (stb_i && hiz_i) state_d = PS_DOWN;
            else if (idle_i)         state_d = PS_DOWN;
         end
         PS_DOWN: begin
            if (stb_i && !pd_i) state_d = PS_ACTIVE;
         end
         default: state_d = PS_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_ACTIVE;
      else        state_q <= state_d;
   end

   assign down_o   = (state_q == PS_DOWN);
   assign hold_o   = down_o;
   assign debias_o = down_o;
   assign cp_hiz_o = down_o | (hiz_i & (state_q == PS_ACTIVE)) | (hiz_i & (state_q == PS_WAIT));
endmodule

// File: rtl/pll_pwrdn_osc_gate.sv
module pll_pwrdn_osc_gate #(
   parameter int unsigned NUM_LOOPS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] down_i,
   output logic                 osc_off_o
);
   logic [NUM_LOOPS:0] all_down;
   assign all_down[0] = 1'b1;
   for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_and
      assign all_down[g+1] = all_down[g] & down_i[g];
   end

   logic unused_clk;
   assign unused_clk = clk & rst_n;
   assign osc_off_o  = all_down[NUM_LOOPS];
endmodule

// File: rtl/pll_pwrdn_ctrl.sv
module pll_pwrdn_ctrl #(
   parameter int unsigned NUM_LOOPS        = 2,
   parameter int unsigned IDLE_SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] latch_stb,
   input  logic [NUM_LOOPS-1:0] ref_hiz_bit,
   input  logic [NUM_LOOPS-1:0] pd_bit,
   input  logic [NUM_LOOPS-1:0] cp_idle,
   output logic [NUM_LOOPS-1:0] loop_down,
   output logic [NUM_LOOPS-1:0] div_hold,
   output logic [NUM_LOOPS-1:0] fin_debias,
   output logic [NUM_LOOPS-1:0] cp_hiz,
   output logic                 osc_off
);
   if (NUM_LOOPS < 1 || NUM_LOOPS > pll_pwrdn_pkg::MAX_LOOPS) begin : g_bad_loops
      $error("pll_pwrdn_ctrl: NUM_LOOPS out of range");
   end

   logic [NUM_LOOPS-1:0] idle_sync;

   for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_loop
      pll_pwrdn_idle_sync #(.STAGES(IDLE_SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .idle_i (cp_idle[l]),
         .idle_o (idle_sync[l])
      );

      pll_pwrdn_loop_fsm u_fsm (
         .clk      (clk),
         .rst_n    (rst_n),
         .stb_i    (latch_stb[l]),
         .hiz_i    (ref_hiz_bit[l]),
         .pd_i     (pd_bit[l]),
         .idle_i   (idle_sync[l]),
         .down_o   (loop_down[l]),
         .hold_o   (div_hold[l]),
         .debias_o (fin_debias[l]),
         .cp_hiz_o (cp_hiz[l])
      );
   end

   pll_pwrdn_osc_gate #(.NUM_LOOPS(NUM_LOOPS)) u_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .down_i    (loop_down),
      .osc_off_o (osc_off)
   );
endmodule

// File: rtl/pll_pwrdn_ctrl_chk.sv
module pll_pwrdn_ctrl_chk #(
   parameter int unsigned NUM_LOOPS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LOOPS-1:0] latch_stb,
   input logic [NUM_LOOPS-1:0] ref_hiz_bit,
   input logic [NUM_LOOPS-1:0] pd_bit,
   input logic [NUM_LOOPS-1:0] loop_down,
   input logic [NUM_LOOPS-1:0] div_hold,
   input logic [NUM_LOOPS-1:0] fin_debias,
   input logic [NUM_LOOPS-1:0] cp_hiz,
   input logic                 osc_off
);
   for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_chk
      p_async_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_stb[l] && pd_bit[l] && ref_hiz_bit[l]) |=> loop_down[l]);

      p_sync_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_stb[l] && pd_bit[l] && !ref_hiz_bit[l] && !loop_down[l]) |=> !loop_down[l]);

      p_power_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_stb[l] && !pd_bit[l]) |=> !loop_down[l]);

      p_stay_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (loop_down[l] && !latch_stb[l]) |=> loop_down[l]);

      p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
         loop_down[l] |-> (div_hold[l] && fin_debias[l] && cp_hiz[l]));

      p_group_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !loop_down[l] |-> (!div_hold[l] && !fin_debias[l]));
   end

   p_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off == (loop_down == {NUM_LOOPS{1'b1}}));
endmodule

bind pll_pwrdn_ctrl pll_pwrdn_ctrl_chk #(.NUM_LOOPS(NUM_LOOPS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .latch_stb   (latch_stb),
   .ref_hiz_bit (ref_hiz_bit),
   .pd_bit      (pd_bit),
   .loop_down   (loop_down),
   .div_hold    (div_hold),
   .fin_debias  (fin_debias),
   .cp_hiz      (cp_hiz),
   .osc_off     (osc_off)
);

// File: tb/pll_pwrdn_ctrl_bench.sv
module pll_pwrdn_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NL         = 2;
   localparam int STG        = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] latch_stb = '0;
   logic [NL-1:0] ref_hiz_bit = '0;
   logic [NL-1:0] pd_bit = '0;
   logic [NL-1:0] cp_idle = '0;
   logic [NL-1:0] loop_down, div_hold, fin_debias, cp_hiz;
   logic          osc_off;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_pwrdn_ctrl #(.NUM_LOOPS(NL), .IDLE_SYNC_STAGES(STG)) u_pll_pwrdn_ctrl (
      .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .ref_hiz_bit(ref_hiz_bit),
      .pd_bit(pd_bit), .cp_idle(cp_idle), .loop_down(loop_down), .div_hold(div_hold),
      .fin_debias(fin_debias), .cp_hiz(cp_hiz), .osc_off(osc_off)
   );

   task automatic chk(string req, string what, logic actual, logic expected);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, actual, expected);
      end
   endtask

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drive a strobe on one loop; returns after the sampling edge
   task automatic strobe(int l, logic hiz, logic pd);
      ref_hiz_bit[l] = hiz;
      pd_bit[l]      = pd;
      latch_stb[l]   = 1'b1;
      @(negedge clk);
      latch_stb[l]   = 1'b0;
      pd_bit[l]      = 1'b0;
   endtask

   task automatic t_reset();
      cycles(1);
      chk("R1", "loop_down", |loop_down, 1'b0);
      chk("R1", "div_hold", |div_hold, 1'b0);
      chk("R1", "fin_debias", |fin_debias, 1'b0);
      chk("R1", "cp_hiz", |cp_hiz, 1'b0);
      chk("R1", "osc_off", osc_off, 1'b0);
   endtask

   task automatic t_active_modes();
      strobe(0, 1'b0, 1'b0);
      chk("R2", "loop_down0", loop_down[0], 1'b0);
      chk("R2", "cp_hiz0", cp_hiz[0], 1'b0);
      strobe(0, 1'b1, 1'b0);
      chk("R3", "loop_down0", loop_down[0], 1'b0);
      chk("R3", "cp_hiz0", cp_hiz[0], 1'b1);
      chk("R3", "div_hold0", div_hold[0], 1'b0);
      ref_hiz_bit[0] = 1'b0;
      cycles(1);
   endtask

   task automatic t_sync_then_async();
      cp_idle[0] = 1'b0;
      strobe(0, 1'b0, 1'b1);
      cycles(5);
      chk("R4", "waiting loop_down0", loop_down[0], 1'b0);
      cp_idle[0] = 1'b1;
      cycles(STG);
      chk("R4", "before latency loop_down0", loop_down[0], 1'b0);
      cycles(1);
      chk("R4", "after latency loop_down0", loop_down[0], 1'b1);
      chk("R6", "div_hold0", div_hold[0], 1'b1);
      chk("R6", "fin_debias0", fin_debias[0], 1'b1);
      chk("R6", "cp_hiz0", cp_hiz[0], 1'b1);
      chk("R7", "osc_off one loop", osc_off, 1'b0);
      chk("R10", "other loop untouched", loop_down[1], 1'b0);
      cp_idle[1] = 1'b0;
      strobe(1, 1'b1, 1'b1);
      chk("R5", "async loop_down1", loop_down[1], 1'b1);
      chk("R7", "osc_off all down", osc_off, 1'b1);
      pd_bit[0] = 1'b0;
      pd_bit[1] = 1'b0;
      cycles(3);
      chk("R10", "pd_bit without strobe loop0", loop_down[0], 1'b1);
      chk("R10", "pd_bit without strobe loop1", loop_down[1], 1'b1);
      strobe(1, 1'b1, 1'b1);
      chk("R10", "re-strobe keeps down", loop_down[1], 1'b1);
      strobe(0, 1'b0, 1'b0);
      chk("R8", "sync-mode power up loop0", loop_down[0], 1'b0);
      chk("R7", "osc_off after power up", osc_off, 1'b0);
      chk("R10", "loop1 unaffected", loop_down[1], 1'b1);
      strobe(1, 1'b1, 1'b0);
      chk("R8", "async-mode power up loop1", loop_down[1], 1'b0);
      ref_hiz_bit = '0;
      cp_idle = '0;
      cycles(STG + 1);
   endtask

   task automatic t_sync_idle_already();
      cp_idle[1] = 1'b1;
      cycles(STG + 1);
      strobe(1, 1'b0, 1'b1);
      chk("R4", "one edge after strobe", loop_down[1], 1'b0);
      cycles(1);
      chk("R4", "idle already high", loop_down[1], 1'b1);
      strobe(1, 1'b0, 1'b0);
      chk("R8", "power up loop1", loop_down[1], 1'b0);
      cp_idle[1] = 1'b0;
      cycles(STG + 1);
   endtask

   task automatic t_cancel();
      strobe(0, 1'b0, 1'b1);
      cycles(2);
      strobe(0, 1'b0, 1'b0);
      cp_idle[0] = 1'b1;
      cycles(STG + 5);
      chk("R9", "cancelled request", loop_down[0], 1'b0);
      chk("R9", "div_hold0", div_hold[0], 1'b0);
      cp_idle[0] = 1'b0;
      cycles(STG + 1);
   endtask

   task automatic t_async_over_wait();
      strobe(0, 1'b0, 1'b1);
      cycles(3);
      chk("R11", "still waiting", loop_down[0], 1'b0);
      strobe(0, 1'b1, 1'b1);
      chk("R11", "async overrides wait", loop_down[0], 1'b1);
      strobe(0, 1'b1, 1'b0);
      chk("R8", "power up after override", loop_down[0], 1'b0);
      ref_hiz_bit[0] = 1'b0;
      cycles(1);
   endtask

   initial begin
      cycles(3);
      t_reset();
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_active_modes();
      t_sync_then_async();
      t_sync_idle_already();
      t_cancel();
      t_async_over_wait();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule